// File: doc/BRIEF.md
# PCM voice serial port

This block carries one voice sample per frame between a parallel sample interface and a pair of serial data lines. A bit clock and a frame-sync line come from outside. Both are sampled by the block's own system clock, which must run at least four times faster than the bit clock. Once a frame start is seen, the next rising bit-clock edge opens a slot. The block then shifts the formatted transmit word out on rising edges and collects the receive word on falling edges. After the slot closes, the receive word is decoded back into a sign-extended 16-bit sample.

The block takes a static configuration word while slots run. It sets the sync style, the sample width and slot length, and how a short sample fills a 16-bit slot: low-end padding that can carry a 3-bit gain code, or sign extension. It also sets the bit order, when the data line is released, and muting. The block drives a separate output-enable for the serial data line.

Configuration word `cfg_i` fields:
- bit 0: short_sync
- bit 1: sign_ext
- bit 2: lsb_first
- bit 3: tri_en
- bit 4: tri_rise
- bit 5: mute
- bits [7:6]: fmt
- bits [10:8]: gain

Top module: `pcm_voice_port`

## Requirements
- R1: With cfg_i[0]=0 (long sync), a rising edge on fsync_i arms a frame. The next rising bclk_i edge opens the slot and drives the slot's first bit on sd_o.
- R2: With cfg_i[0]=1 (short sync), a falling edge on fsync_i arms the frame, and a rising edge is ignored.
- R3: fmt (cfg_i[7:6]) = 01 sends tx_sample_i unchanged in a 16-cycle slot. The received 16-bit word is returned unchanged.
- R4: fmt=00 with cfg_i[1]=0 sends the slot word {sample[12:0], cfg_i[10:8]}. On receive, word[15:3] is returned sign-extended to 16 bits.
- R5: With cfg_i[1]=1 and fmt 00 or 10, the slot word is the sample sign-extended from bit 12 or bit 7. On receive, the low 13 or 8 bits are returned sign-extended.
- R6: fmt=10 with cfg_i[1]=0 sends {sample[7:0], 8'h00} and returns word[15:8] sign-extended. fmt=11 uses an 8-cycle slot carrying sample[7:0] and returns it sign-extended.
- R7: cfg_i[2]=0 sends and receives the slot word MSB first. cfg_i[2]=1 sends and receives it LSB first.
- R8: With cfg_i[3]=0, sd_oe_o is high from the first cycle after reset. A rising bclk_i edge outside a slot drives sd_o to 0.
- R9: With cfg_i[3]=1 and cfg_i[4]=0, sd_oe_o is high for the whole slot. It drops at the falling bclk_i edge that ends the last bit, unless the next frame start has already been seen; in that case it stays high.
- R10: With cfg_i[3]=1 and cfg_i[4]=1, sd_oe_o stays high past the last falling edge. It drops at the following rising bclk_i edge when no slot opens there.
- R11: cfg_i[5]=1 holds sd_o at 0 and leaves sd_oe_o and the receive path unchanged.
- R12: While rst_n is low, sd_oe_o, sd_o and rx_valid_o are 0.
- R13: rx_valid_o pulses for one clock cycle, in the cycle after the clock edge at which the slot's last falling bclk_i edge is detected. rx_sample_o holds the decoded sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 11 | Configuration word, field layout above |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync |
| sd_i | input | 1 | Serial data in, sampled on falling bclk_i |
| tx_sample_i | input | 16 | Sample to transmit, captured when a slot opens |
| sd_o | output | 1 | Serial data out, changes on rising bclk_i |
| sd_oe_o | output | 1 | Output-enable for sd_o |
| rx_sample_o | output | 16 | Last received sample, sign-extended |
| rx_valid_o | output | 1 | One-cycle pulse when rx_sample_o is updated |

## Verification
The delicate coincidence is a slot ending while the next frame start is already armed. In the same bit-clock period, the release of the data line and the opening of the next slot both want to steer sd_oe_o. The bench provokes this by raising or dropping the sync line during the high phase of a slot's last bit, then starting the next frame directly on the following rising edge. It expects sd_oe_o to stay high across the boundary, and the first bit of the new slot to appear without a gap, for both release edges.

// File: rtl/pcm_vp_pkg.sv
package pcm_vp_pkg;
  localparam int SLOT_W = 16;
  localparam int CNT_W  = $clog2(SLOT_W);
  localparam int LEN_W  = CNT_W + 1;
  localparam int CFG_W  = 11;

  typedef struct packed {
    logic [2:0] gain;
    logic [1:0] fmt;
    logic       mute;
    logic       tri_rise;
    logic       tri_en;
    logic       lsb_first;
    logic       sign_ext;
    logic       short_sync;
  } cfg_t;

  function automatic logic [LEN_W-1:0] slot_len(input logic [1:0] fmt);
    return (fmt == 2'b11) ? LEN_W'(SLOT_W / 2) : LEN_W'(SLOT_W);
  endfunction

  // sample -> slot word
  function automatic logic [SLOT_W-1:0] pack_word(input cfg_t c, input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] w;
    case (c.fmt)
      2'b00:   w = c.sign_ext ? {{3{s[12]}}, s[12:0]} : {s[12:0], c.gain};
      2'b01:   w = s;
      2'b10:   w = c.sign_ext ? {{8{s[7]}}, s[7:0]} : {s[7:0], 8'h00};
      default: w = {8'h00, s[7:0]};
    endcase
    return w;
  endfunction

  // slot word -> sign-extended sample
  function automatic logic [SLOT_W-1:0] unpack_word(input cfg_t c, input logic [SLOT_W-1:0] w);
    logic [SLOT_W-1:0] s;
    case (c.fmt)
      2'b00:   s = c.sign_ext ? {{3{w[12]}}, w[12:0]} : {{3{w[15]}}, w[15:3]};
      2'b01:   s = w;
      2'b10:   s = c.sign_ext ? {{8{w[7]}}, w[7:0]} : {{8{w[15]}}, w[15:8]};
      default: s = {{8{w[7]}}, w[7:0]};
    endcase
    return s;
  endfunction

  // serial position idx -> bit index inside the slot word
  function automatic logic [CNT_W-1:0] bit_pos(input cfg_t c, input logic [CNT_W-1:0] idx);
    logic [LEN_W-1:0] top;
    top = slot_len(c.fmt) - LEN_W'(1);
    return c.lsb_first ? idx : CNT_W'(top - {1'b0, idx});
  endfunction
endpackage

// File: rtl/pcm_vp_edge.sv
module pcm_vp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic short_sync,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic frame_edge
);
  logic bclk_q, fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      fs_q   <= fsync_i;
    end
  end

  assign bclk_rise  = bclk_i & ~bclk_q;
  assign bclk_fall  = ~bclk_i & bclk_q;
  assign frame_edge = short_sync ? (~fsync_i & fs_q) : (fsync_i & ~fs_q);
endmodule

// File: rtl/pcm_vp_seq.sv
module pcm_vp_seq
  import pcm_vp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  input  logic             frame_edge,
  input  logic [1:0]       fmt,
  output logic             slot_start,
  output logic             slot_armed,
  output logic             slot_active,
  output logic             last_fall,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] bit_cnt_nxt
);
  assign slot_start  = bclk_rise & slot_armed;
  assign last_fall   = bclk_fall & slot_active &
                       ({1'b0, bit_cnt} == slot_len(fmt) - LEN_W'(1));
  assign bit_cnt_nxt = slot_start ? '0 : bit_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_armed  <= 1'b0;
      slot_active <= 1'b0;
      bit_cnt     <= '0;
    end else begin
      if (slot_start)      slot_armed <= frame_edge;
      else if (frame_edge) slot_armed <= 1'b1;

      if (slot_start)     slot_active <= 1'b1;
      else if (last_fall) slot_active <= 1'b0;

      if (slot_start)                    bit_cnt <= '0;
      else if (bclk_rise && slot_active) bit_cnt <= bit_cnt_nxt;
    end
  end

  assert_slot_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (slot_active && bit_cnt == '0));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_active |-> ({1'b0, bit_cnt} < slot_len(fmt)));
endmodule

// File: rtl/pcm_vp_tx.sv
module pcm_vp_tx
  import pcm_vp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              bclk_rise,
  input  logic              slot_start,
  input  logic              slot_active,
  input  logic              slot_armed,
  input  logic              last_fall,
  input  logic [CNT_W-1:0]  bit_cnt_nxt,
  input  logic [SLOT_W-1:0] tx_sample,
  output logic              sd_o,
  output logic              sd_oe_o
);
  logic [SLOT_W-1:0] word_q, word_sel;
  logic              sd_q, oe_q, rel_pend, drive_bit;

  assign word_sel  = slot_start ? pack_word(cfg, tx_sample) : word_q;
  assign drive_bit = word_sel[bit_pos(cfg, bit_cnt_nxt)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      sd_q     <= 1'b0;
      oe_q     <= 1'b0;
      rel_pend <= 1'b0;
    end else begin
      if (slot_start) word_q <= word_sel;
      if (bclk_rise)  sd_q   <= (slot_start | slot_active) ? drive_bit : 1'b0;

      if (last_fall)      rel_pend <= cfg.tri_rise;
      else if (bclk_rise) rel_pend <= 1'b0;

      if (!cfg.tri_en)                                   oe_q <= 1'b1;
      else if (slot_start)                               oe_q <= 1'b1;
      else if (last_fall && !cfg.tri_rise && !slot_armed) oe_q <= 1'b0;
      else if (rel_pend && bclk_rise)                    oe_q <= 1'b0;
    end
  end

  assign sd_o    = sd_q & ~cfg.mute;
  assign sd_oe_o = oe_q;

  assert_drive_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.tri_en |=> sd_oe_o);

  assert_oe_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> sd_oe_o);

  assert_oe_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && !slot_start) |-> sd_oe_o);
endmodule

// File: rtl/pcm_vp_rx.sv
module pcm_vp_rx
  import pcm_vp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              bclk_fall,
  input  logic              slot_active,
  input  logic              last_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              sd_i,
  output logic [SLOT_W-1:0] rx_sample,
  output logic              rx_valid
);
  logic [SLOT_W-1:0] rx_word;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
      done_q  <= 1'b0;
    end else begin
      if (bclk_fall && slot_active) rx_word[bit_pos(cfg, bit_cnt)] <= sd_i;
      done_q <= last_fall;
    end
  end

  assign rx_sample = unpack_word(cfg, rx_word);
  assign rx_valid  = done_q;

  assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_vp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sd_i,
  input  logic [SLOT_W-1:0] tx_sample_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic [SLOT_W-1:0] rx_sample_o,
  output logic              rx_valid_o
);
  cfg_t             cfg;
  logic             bclk_rise, bclk_fall, frame_edge;
  logic             slot_start, slot_armed, slot_active, last_fall;
  logic [CNT_W-1:0] bit_cnt, bit_cnt_nxt;

  assign cfg = cfg_t'(cfg_i);

  pcm_vp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .short_sync(cfg.short_sync), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .frame_edge(frame_edge)
  );

  pcm_vp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .frame_edge(frame_edge), .fmt(cfg.fmt), .slot_start(slot_start),
    .slot_armed(slot_armed), .slot_active(slot_active), .last_fall(last_fall),
    .bit_cnt(bit_cnt), .bit_cnt_nxt(bit_cnt_nxt)
  );

  pcm_vp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .bclk_rise(bclk_rise),
    .slot_start(slot_start), .slot_active(slot_active), .slot_armed(slot_armed),
    .last_fall(last_fall), .bit_cnt_nxt(bit_cnt_nxt), .tx_sample(tx_sample_i),
    .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );

  pcm_vp_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .bclk_fall(bclk_fall),
    .slot_active(slot_active), .last_fall(last_fall), .bit_cnt(bit_cnt),
    .sd_i(sd_i), .rx_sample(rx_sample_o), .rx_valid(rx_valid_o)
  );
endmodule

// File: tb/pcm_voice_port_test.sv
`timescale 1ns/1ps
module pcm_voice_port_test;
  logic        clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fsync = 1'b0, sd_in = 1'b0;
  logic [10:0] cfg = 11'h040;
  logic [15:0] txs = '0;
  logic        sd_o, oe, rx_valid;
  logic [15:0] rx_sample;
  int          nchk = 0, nbad = 0;

  always #2.5 clk = ~clk;

  pcm_voice_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .bclk_i(bclk), .fsync_i(fsync),
    .sd_i(sd_in), .tx_sample_i(txs), .sd_o(sd_o), .sd_oe_o(oe),
    .rx_sample_o(rx_sample), .rx_valid_o(rx_valid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int slen(input logic [10:0] c);
    return (c[7:6] == 2'd3) ? 8 : 16;
  endfunction

  // slot word the requirements prescribe for sample s
  function automatic logic [15:0] model_word(input logic [10:0] c, input logic [15:0] s);
    int v;
    case (c[7:6])
      2'd0: v = c[1] ? int'($signed(s[12:0])) : int'(s[12:0]) * 8 + int'(c[10:8]);
      2'd1: v = int'(s);
      2'd2: v = c[1] ? int'($signed(s[7:0])) : int'(s[7:0]) * 256;
      default: v = int'(s[7:0]);
    endcase
    return v[15:0];
  endfunction

  // sample the receiver must return when the peer sent model_word(c, r)
  function automatic logic [15:0] model_rx(input logic [10:0] c, input logic [15:0] r);
    int v;
    if (c[7:6] == 2'd1) v = int'(r);
    else if (c[7:6] == 2'd0) v = int'($signed(r[12:0]));
    else v = int'($signed(r[7:0]));
    return v[15:0];
  endfunction

  function automatic string data_req(input logic [10:0] c);
    if (c[5]) return "R11";
    if (c[2]) return "R7";
    case (c[7:6])
      2'd0: return c[1] ? "R5" : "R4";
      2'd1: return "R3";
      2'd2: return c[1] ? "R5" : "R6";
      default: return "R6";
    endcase
  endfunction

  task automatic set_cfg(input logic [10:0] c);
    cfg = c;
    tick(1);
    fsync = c[0];   // idle level: low for long sync, high for short sync
    tick(2);
  endtask

  task automatic frame(input logic [10:0] c, input logic [15:0] s, input logic [15:0] r,
                       input bit pre, input bit chain);
    int          n;
    logic [15:0] tw, rw;
    logic        act_lvl, exp_bit;
    n  = slen(c);
    tw = model_word(c, s);
    rw = model_word(c, r);
    act_lvl = ~c[0];
    txs = s;
    if (!pre) begin
      fsync = act_lvl;     // R1 / R2 frame start
      tick(2);
    end
    for (int k = 0; k < n; k++) begin
      bclk = 1'b1;
      tick(1);
      exp_bit = c[5] ? 1'b0 : (c[2] ? tw[k] : tw[n-1-k]);
      if (k == 0) chk(c[0] ? "R2 first bit" : "R1 first bit", {15'd0, sd_o}, {15'd0, exp_bit});
      else        chk(data_req(c), {15'd0, sd_o}, {15'd0, exp_bit});
      chk(c[3] ? "R9 oe in slot" : "R8 oe in slot", {15'd0, oe}, 16'd1);
      tick(1);
      if (k == 0) fsync = ~act_lvl;
      if (chain && k == n - 1) fsync = act_lvl;
      tick(1);
      sd_in = c[2] ? rw[k] : rw[n-1-k];
      bclk  = 1'b0;
      tick(1);
      if (k == n - 1) begin
        chk("R13 valid pulse", {15'd0, rx_valid}, 16'd1);
        chk("R13 rx sample", rx_sample, model_rx(c, r));
        chk(c[4] ? "R10 oe held" : "R9 oe release", {15'd0, oe},
            {15'd0, !(c[3] && !c[4] && !chain)});
        tick(1);
        chk("R13 pulse width", {15'd0, rx_valid}, 16'd0);
      end else begin
        chk("R13 no early valid", {15'd0, rx_valid}, 16'd0);
      end
      tick(1);
    end
    if (!chain) begin
      bclk = 1'b1;
      tick(1);
      chk(c[3] ? "R10 idle oe" : "R8 idle oe", {15'd0, oe}, {15'd0, !c[3]});
      chk("R8 idle data", {15'd0, sd_o}, 16'd0);
      tick(1);
      bclk = 1'b0;
      tick(2);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    tick(3);
    chk("R12 reset oe", {15'd0, oe}, 16'd0);
    chk("R12 reset data", {15'd0, sd_o}, 16'd0);
    chk("R12 reset valid", {15'd0, rx_valid}, 16'd0);
    rst_n = 1'b1;
    tick(2);
    chk("R8 oe after reset", {15'd0, oe}, 16'd1);

    // directed formats: {gain, fmt, mute, tri_rise, tri_en, lsb, sign, short}
    set_cfg({3'd0, 2'd1, 6'b000000}); frame(cfg, 16'hA53C, 16'h8001, 0, 0);
    set_cfg({3'd5, 2'd0, 6'b001000}); frame(cfg, 16'h1ABC, 16'h0F0F, 0, 0);
    set_cfg({3'd0, 2'd0, 6'b000010}); frame(cfg, 16'h1001, 16'h1F00, 0, 0);
    set_cfg({3'd0, 2'd2, 6'b011001}); frame(cfg, 16'h0081, 16'h0080, 0, 0);
    set_cfg({3'd0, 2'd2, 6'b000110}); frame(cfg, 16'h00FE, 16'h007F, 0, 0);
    set_cfg({3'd0, 2'd3, 6'b000101}); frame(cfg, 16'h00C3, 16'h0096, 0, 0);
    set_cfg({3'd0, 2'd1, 6'b100000}); frame(cfg, 16'hFFFF, 16'h1234, 0, 0);
    // slot end meets armed next frame, both release edges
    set_cfg({3'd0, 2'd1, 6'b001000});
    frame(cfg, 16'h5555, 16'h3C3C, 0, 1);
    frame(cfg, 16'hAAAA, 16'hC3C3, 1, 0);
    set_cfg({3'd2, 2'd3, 6'b011001});
    frame(cfg, 16'h0011, 16'h00EE, 0, 1);
    frame(cfg, 16'h0022, 16'h0077, 1, 0);

    for (int i = 0; i < 40; i++) begin
      logic [10:0] c;
      c = 11'($urandom());
      c[5] = (($urandom() % 8) == 0);
      set_cfg(c);
      frame(c, 16'($urandom()), 16'($urandom()), 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule